// File: doc/BRIEF.md
# Multi-mode programmable delay timer

This block watches a trigger line and drives an output that is the logical inverse of it: a low trigger calls for the output to be on, a high trigger calls for it to be off. Depending on the selected mode, the turn-on, the turn-off, both or neither is held back by a programmed delay. A fourth mode turns the block into a retriggerable monostable. All timing is counted in periods of a slow time base. The time base is either an internal oscillator signal or an external one, and it is sampled by a much faster system clock.

The delay is 1 + 1023·N time-base periods. N is read from a five-bit active-low weighting word. The count runs through a fixed divide-by-1023 prescaler, and a major counter holds N. The trigger, the mode pins and the weighting word are all latched together on a falling edge of the selected time base. Output changes land on rising time-base edges, except that the one-shot turn-on lands on the falling edge that latched the trigger.

Top module: `prog_delay_timer`

## Requirements
- R1: After reset the output is off, the latched trigger is 1, the latched mode is dual delay and the latched N is 0.
- R2: `tb_sel`=1 selects `tb_ext` as time base and `tb_sel`=0 selects `tb_int`; toggling the unselected source has no effect on the output.
- R3: Trigger, mode and weighting inputs act only through the values latched on a falling time-base edge; a change between falling edges has no effect until the next falling edge.
- R4: N is the sum of 2^i over every bit i of `wt_n` that is 0 (bit 0 weighs 1, bit 4 weighs 16); a delayed change takes effect on the (1+1023·N)-th rising time-base edge after the falling edge that latched the trigger edge.
- R5: Mode is `{mode_a, mode_b}`: 2'b11 dual delay, 2'b10 delayed release, 2'b01 delayed operate, 2'b00 one-shot.
- R6: In dual delay both turn-on and turn-off are delayed; if the latched trigger returns to its former level before the delay ends, the pending change is dropped and the output keeps its state.
- R7: In delayed operate a falling trigger starts a delayed turn-on, and a rising trigger turns the output off on the next rising time-base edge, dropping any pending turn-on.
- R8: In delayed release a rising trigger starts a delayed turn-off, and a falling trigger turns the output on on the next rising time-base edge, dropping any pending turn-off.
- R9: In one-shot a falling trigger turns the output on at the falling time-base edge that latched it and starts the delay; the output turns off when the delay ends; a new falling trigger during the delay restarts it.
- R10: In one-shot a rising trigger has no effect on the output or on a running delay.
- R11: Outside one-shot, every output change lands on a rising time-base edge; one without delay lands on the first rising edge after the latching falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tb_sel | input | 1 | Time-base select: 1 external, 0 internal |
| tb_int | input | 1 | Internal oscillator time base |
| tb_ext | input | 1 | External time base |
| trig_in | input | 1 | Trigger input |
| mode_a | input | 1 | Mode select, upper bit |
| mode_b | input | 1 | Mode select, lower bit |
| wt_n | input | 5 | Active-low weighting word |
| out_on | output | 1 | Timer output, 1 = on |

## Verification
A time-base edge reaches `out_on` three system-clock cycles after the selected source changes: two synchronizer stages, then the output register. The bench therefore holds each time-base half period for six cycles. It samples on the falling system-clock edge at the end of the half period, so every output that is due has settled. A delayed result is checked in two steps. First the output must still hold its old value after 1023·N whole periods. Then it must have changed after one more period, which places the change on exactly the (1+1023·N)-th rising edge. The one-shot turn-on is sampled inside the low half period, before any rising edge could have produced it.

// File: rtl/pdt_pkg.sv
package pdt_pkg;

    // Mode codes as {mode_a, mode_b}
    typedef enum logic [1:0] {
        MODE_ONESHOT = 2'b00,
        MODE_OPERATE = 2'b01,
        MODE_RELEASE = 2'b10,
        MODE_DUAL    = 2'b11
    } mode_e;

endpackage

// File: rtl/pdt_tick_gen.sv
module pdt_tick_gen #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    input  logic src_int,
    input  logic src_ext,
    output logic tick_rise,
    output logic tick_fall
);
    localparam int LAST = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
    } tg_state_t;

    tg_state_t st_d, st_q;
    logic      src;

    always_comb begin
        src          = sel ? src_ext : src_int;
        st_d         = st_q;
        st_d.sync    = {st_q.sync[SYNC_STAGES-2:0], src};
        st_d.prev    = st_q.sync[LAST];
        tick_rise    = st_q.sync[LAST] & ~st_q.prev;
        tick_fall    = ~st_q.sync[LAST] & st_q.prev;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2: a tick needs a change of the synchronized time base
    a_r2_no_back_to_back_rise: assert property (@(posedge clk) disable iff (!rst_n)
        tick_rise |=> !tick_rise);

endmodule

// File: rtl/pdt_delay_counter.sv
module pdt_delay_counter #(
    parameter int PRESCALE = 1023,
    parameter int WEIGHT_W = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                stop,
    input  logic [WEIGHT_W-1:0] weight,
    input  logic                tick,
    output logic                expire
);
    localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PW-1:0] FRAC_LAST = PW'(PRESCALE - 1);

    typedef struct packed {
        logic                busy;
        logic [PW-1:0]       frac;
        logic [WEIGHT_W-1:0] major;
    } dc_state_t;

    dc_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        expire = st_q.busy & tick & (st_q.major == '0);
        if (start) begin
            st_d.busy  = 1'b1;
            st_d.frac  = '0;
            st_d.major = weight;
        end else if (stop) begin
            st_d.busy = 1'b0;
        end else if (tick && st_q.busy) begin
            if (st_q.major == '0) begin
                st_d.busy = 1'b0;
            end else if (st_q.frac == FRAC_LAST) begin
                st_d.frac  = '0;
                st_d.major = st_q.major - 1'b1;
            end else begin
                st_d.frac = st_q.frac + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4: a running count never moves upward unless reloaded
    a_r4_major_not_rising: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && !start && !stop) |=> (st_q.major <= $past(st_q.major)));

endmodule

// File: rtl/pdt_mode_ctrl.sv
module pdt_mode_ctrl
    import pdt_pkg::*;
#(
    parameter int WEIGHT_W = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_fall,
    input  logic                expire,
    input  logic                trig_in,
    input  logic                mode_a,
    input  logic                mode_b,
    input  logic [WEIGHT_W-1:0] wt_n,
    output logic                start,
    output logic                stop,
    output logic [WEIGHT_W-1:0] load_n,
    output logic                out_on
);
    typedef struct packed {
        logic  trig_l;
        mode_e mode;
        logic  out;
        logic  tgt;
    } mc_state_t;

    mc_state_t st_d, st_q;
    logic                fell, rose, want_on;
    logic [WEIGHT_W-1:0] n_in;

    always_comb begin
        st_d    = st_q;
        start   = 1'b0;
        stop    = 1'b0;
        load_n  = '0;
        n_in    = ~wt_n;
        fell    = tick_fall & st_q.trig_l & ~trig_in;
        rose    = tick_fall & ~st_q.trig_l & trig_in;
        want_on = fell;
        if (tick_fall) begin
            st_d.trig_l = trig_in;
            st_d.mode   = mode_e'({mode_a, mode_b});
            unique case (st_d.mode)
                MODE_DUAL: begin
                    if (fell || rose) begin
                        if (st_q.out == want_on) begin
                            stop = 1'b1;
                        end else begin
                            start    = 1'b1;
                            load_n   = n_in;
                            st_d.tgt = want_on;
                        end
                    end
                end
                MODE_OPERATE: begin
                    if (fell) begin
                        start    = 1'b1;
                        load_n   = n_in;
                        st_d.tgt = 1'b1;
                    end else if (rose) begin
                        start    = 1'b1;
                        st_d.tgt = 1'b0;
                    end
                end
                MODE_RELEASE: begin
                    if (rose) begin
                        start    = 1'b1;
                        load_n   = n_in;
                        st_d.tgt = 1'b0;
                    end else if (fell) begin
                        start    = 1'b1;
                        st_d.tgt = 1'b1;
                    end
                end
                MODE_ONESHOT: begin
                    if (fell) begin
                        st_d.out = 1'b1;
                        start    = 1'b1;
                        load_n   = n_in;
                        st_d.tgt = 1'b0;
                    end
                end
                default: ;
            endcase
        end
        if (expire) st_d.out = st_q.tgt;
        out_on = st_q.out;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.trig_l <= 1'b1;
            st_q.mode   <= MODE_DUAL;
            st_q.out    <= 1'b0;
            st_q.tgt    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    // R6: apart from the one-shot turn-on, the output moves only when the delay ends
    a_r6_out_only_on_expire: assert property (@(posedge clk) disable iff (!rst_n)
        (!expire && !(tick_fall && {mode_a, mode_b} == MODE_ONESHOT)) |=> $stable(out_on));

    // R9: in one-shot an off output can only turn on at a falling time-base edge
    a_r9_oneshot_on_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_fall && st_q.mode == MODE_ONESHOT && !st_q.out) |=> !out_on);

    // R10: a rising trigger latched in one-shot leaves the output alone
    a_r10_oneshot_rise_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_fall && {mode_a, mode_b} == MODE_ONESHOT && trig_in && !expire) |=> $stable(out_on));

endmodule

// File: rtl/prog_delay_timer.sv
module prog_delay_timer #(
    parameter int PRESCALE    = 1023,
    parameter int WEIGHT_W    = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tb_sel,
    input  logic                tb_int,
    input  logic                tb_ext,
    input  logic                trig_in,
    input  logic                mode_a,
    input  logic                mode_b,
    input  logic [WEIGHT_W-1:0] wt_n,
    output logic                out_on
);
    logic                tick_rise, tick_fall;
    logic                start, stop, expire;
    logic [WEIGHT_W-1:0] load_n;

    pdt_tick_gen #(
        .SYNC_STAGES(SYNC_STAGES)
    ) i_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (tb_sel),
        .src_int  (tb_int),
        .src_ext  (tb_ext),
        .tick_rise(tick_rise),
        .tick_fall(tick_fall)
    );

    pdt_mode_ctrl #(
        .WEIGHT_W(WEIGHT_W)
    ) i_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_fall(tick_fall),
        .expire   (expire),
        .trig_in  (trig_in),
        .mode_a   (mode_a),
        .mode_b   (mode_b),
        .wt_n     (wt_n),
        .start    (start),
        .stop     (stop),
        .load_n   (load_n),
        .out_on   (out_on)
    );

    pdt_delay_counter #(
        .PRESCALE(PRESCALE),
        .WEIGHT_W(WEIGHT_W)
    ) i_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .stop   (stop),
        .weight (load_n),
        .tick   (tick_rise),
        .expire (expire)
    );

    // R3: without a time-base edge the output holds
    a_r3_out_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_rise && !tick_fall) |=> $stable(out_on));

    // R11: a time-base edge starts or ends a delay, never both at once
    a_r11_edges_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(start && expire));

endmodule

// File: tb/test_prog_delay_timer.sv
module test_prog_delay_timer;
    localparam int HALF = 6;
    localparam int NVEC = 27;

    typedef struct packed {
        logic [1:0]  mode;
        logic [4:0]  wt;
        logic        trig;
        logic [11:0] periods;
        logic        exp;
        logic [3:0]  req;
    } vec_t;

    // rows: {mode_a,mode_b}, wt_n, trigger, periods to run, expected out, requirement
    localparam vec_t VECS [NVEC] = '{
        '{2'b11, 5'h1F, 1'b1, 12'd2,    1'b0, 4'd5},  // R5 idle in dual
        '{2'b11, 5'h1F, 1'b0, 12'd1,    1'b1, 4'd11}, // R11 N=0 turn-on
        '{2'b11, 5'h1F, 1'b1, 12'd1,    1'b0, 4'd11}, // R11 N=0 turn-off
        '{2'b11, 5'h1E, 1'b0, 12'd1023, 1'b0, 4'd4},  // R4 N=1 not yet
        '{2'b11, 5'h1E, 1'b0, 12'd1,    1'b1, 4'd4},  // R4 N=1 on
        '{2'b11, 5'h1E, 1'b1, 12'd500,  1'b1, 4'd6},  // R6 off pending
        '{2'b11, 5'h1E, 1'b0, 12'd1000, 1'b1, 4'd6},  // R6 cancelled
        '{2'b01, 5'h1E, 1'b1, 12'd1,    1'b0, 4'd7},  // R7 immediate off
        '{2'b01, 5'h1E, 1'b0, 12'd600,  1'b0, 4'd7},  // R7 on pending
        '{2'b01, 5'h1E, 1'b1, 12'd2,    1'b0, 4'd7},  // R7 cancelled
        '{2'b01, 5'h1E, 1'b0, 12'd1023, 1'b0, 4'd7},  // R7 not yet
        '{2'b01, 5'h1E, 1'b0, 12'd1,    1'b1, 4'd7},  // R7 delayed on
        '{2'b10, 5'h1E, 1'b1, 12'd1023, 1'b1, 4'd8},  // R8 not yet
        '{2'b10, 5'h1E, 1'b1, 12'd1,    1'b0, 4'd8},  // R8 delayed off
        '{2'b10, 5'h1E, 1'b0, 12'd1,    1'b1, 4'd8},  // R8 immediate on
        '{2'b10, 5'h1E, 1'b1, 12'd300,  1'b1, 4'd8},  // R8 off pending
        '{2'b10, 5'h1E, 1'b0, 12'd5,    1'b1, 4'd8},  // R8 cancelled
        '{2'b00, 5'h1F, 1'b1, 12'd2,    1'b1, 4'd10}, // R10 rise ignored
        '{2'b00, 5'h1F, 1'b0, 12'd1,    1'b0, 4'd9},  // R9 N=0 pulse done
        '{2'b00, 5'h1E, 1'b1, 12'd2,    1'b0, 4'd10}, // R10 still off
        '{2'b00, 5'h1E, 1'b0, 12'd1000, 1'b1, 4'd9},  // R9 pulse running
        '{2'b00, 5'h1E, 1'b1, 12'd20,   1'b1, 4'd10}, // R10 rise mid-pulse
        '{2'b00, 5'h1E, 1'b0, 12'd1023, 1'b1, 4'd9},  // R9 retriggered
        '{2'b00, 5'h1E, 1'b0, 12'd1,    1'b0, 4'd9},  // R9 pulse ends
        '{2'b11, 5'h1D, 1'b1, 12'd2,    1'b0, 4'd6},  // R6 setup
        '{2'b11, 5'h1D, 1'b0, 12'd2046, 1'b0, 4'd4},  // R4 N=2 not yet
        '{2'b11, 5'h1D, 1'b0, 12'd1,    1'b1, 4'd4}   // R4 N=2 on
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tb_sel = 1'b0;
    logic       tb_int = 1'b1;
    logic       tb_ext = 1'b1;
    logic       trig_in = 1'b1;
    logic       mode_a = 1'b1;
    logic       mode_b = 1'b1;
    logic [4:0] wt_n = 5'h1F;
    logic       out_on;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    prog_delay_timer i_prog_delay_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .tb_sel (tb_sel),
        .tb_int (tb_int),
        .tb_ext (tb_ext),
        .trig_in(trig_in),
        .mode_a (mode_a),
        .mode_b (mode_b),
        .wt_n   (wt_n),
        .out_on (out_on)
    );

    task automatic check(input logic exp, input int req, input string what);
        n_checks++;
        if (out_on !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: out_on=%b expected %b", req, what, out_on, exp);
        end
    endtask

    task automatic tb_half(input logic level);
        @(negedge clk);
        if (tb_sel) tb_ext = level;
        else        tb_int = level;
        repeat (HALF - 1) @(negedge clk);
    endtask

    task automatic run_periods(input int n);
        for (int i = 0; i < n; i++) begin
            tb_half(1'b0);
            tb_half(1'b1);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            summary();
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(1'b0, 1, "output off after reset");   // R1
        run_periods(1);
        check(1'b0, 1, "no action with reset trigger level");

        for (int v = 0; v < NVEC; v++) begin
            {mode_a, mode_b} = VECS[v].mode;
            wt_n    = VECS[v].wt;
            trig_in = VECS[v].trig;
            run_periods(int'(VECS[v].periods));
            check(VECS[v].exp, int'(VECS[v].req), $sformatf("vector %0d", v));
        end

        // R2: the unselected source is ignored, the selected one acts
        {mode_a, mode_b} = 2'b11;
        wt_n    = 5'h1F;
        trig_in = 1'b1;
        tb_sel  = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); tb_int = 1'b0;
            repeat (HALF) @(negedge clk);
            tb_int = 1'b1;
            repeat (HALF) @(negedge clk);
        end
        check(1'b1, 2, "internal toggles while external selected");
        run_periods(1);
        check(1'b0, 2, "external time base acts");
        tb_sel = 1'b0;
        run_periods(1);

        // R9: one-shot turn-on lands on the falling time-base edge
        {mode_a, mode_b} = 2'b00;
        trig_in = 1'b0;
        tb_half(1'b0);
        check(1'b1, 9, "one-shot on within low half");
        tb_half(1'b1);
        check(1'b0, 9, "one-shot N=0 off at rising edge");

        // R3: trigger change during the high half waits for the next falling edge
        {mode_a, mode_b} = 2'b11;
        trig_in = 1'b1;
        run_periods(2);
        check(1'b0, 3, "settled off");
        tb_half(1'b0);
        trig_in = 1'b0;
        tb_half(1'b1);
        check(1'b0, 3, "change between edges not yet latched");
        run_periods(1);
        check(1'b1, 3, "change acts after next falling edge");

        finished = 1'b1;
        summary();
    end
endmodule